// File: doc/BRIEF.md
# Forty-bit barrel shifter with bit-field operations

This block is the shift unit of a 40-bit arithmetic datapath. Each accepted operation yields one result word one clock later. The unit performs arithmetic and logical shifts and rotates, selected by a signed shift amount. It also counts redundant sign bits, so a caller can normalize a value with one left shift. Two bit-field operations are included: one extracts a field, and one inserts a field into a word.

A caller presents an operation code, a 40-bit operand and the controls for that operation, and raises `in_valid`. A 32-bit operand can be widened into the 40-bit path by sign extension. The result appears one cycle later, registered, together with a zero flag and a sign flag. When no operation is presented, the outputs keep their last values.

Top module: `wide_shifter`

## Requirements
- R1: Outputs are registered with one cycle of latency: `out_valid` equals `in_valid` of the previous cycle. While `in_valid` is low, `result` and the flags keep their values. Synchronous reset clears `out_valid`, `result` and both flags to 0.
- R2: When `narrow` is 1, the operand is bits 31:0 of `src_a`, sign-extended to 40 bits; upper bits of `src_a` are ignored. When `narrow` is 0, all 40 bits are used. Every operation, including insertion, works on this operand.
- R3: `shamt` is a 7-bit two's-complement amount. A value of zero or above shifts left and a negative value shifts right. The magnitude saturates at 39, so -64 acts as a right shift by 39 and +63 acts as a left shift by 39. An amount of 0 returns the operand unchanged.
- R4: Opcode 0 (arithmetic shift): a left shift fills zeros from the bottom; a right shift copies operand bit 39 into the vacated top bits.
- R5: Opcode 1 (logical shift): a left shift fills zeros from the bottom; a right shift fills zeros from the top.
- R6: Opcode 2 (rotate): bits that leave one end of the 40-bit word re-enter at the other end, so no bit is lost. A left rotate moves bit i to bit (i+n) mod 40.
- R7: Opcode 3 (sign count): the result is the number of bits directly below bit 39 that equal bit 39, counted until the first differing bit. It ranges from 0 to 39; 0 and all-ones give 39. The count sits in bits 5:0 and bits 39:6 are zero.
- R8: Opcode 4 (unsigned extract): the position `fpos` saturates at 39 and the length `flen` saturates at 40 minus that position. The field is returned right-justified in the result, with zero upper bits.
- R9: Opcode 5 (signed extract): the field is taken as in R8, and the result's upper bits copy the field's top bit. A length of 0 gives a result of 0 for both extract opcodes.
- R10: Opcode 6 (insert): the low bits of `dep_src` replace the field of the operand, with position and length saturated as in R8. All other bits of the operand pass unchanged.
- R11: `zero_flag` is 1 exactly when the registered result is 0. `sign_flag` equals bit 39 of the registered result.
- R12: Opcode 7 (pass) returns the operand of R2 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation presented this cycle |
| op | input | 3 | Operation code (0..7, see requirements) |
| src_a | input | 40 | Operand |
| narrow | input | 1 | Sign-extend bits 31:0 of the operand |
| shamt | input | 7 | Signed shift/rotate amount |
| fpos | input | 6 | Field position (lowest bit of field) |
| flen | input | 6 | Field length in bits |
| dep_src | input | 40 | Bits to insert (low bits used) |
| out_valid | output | 1 | Result registered for a valid operation |
| result | output | 40 | Registered result |
| zero_flag | output | 1 | Result is zero |
| sign_flag | output | 1 | Bit 39 of result |

## Verification
The bench targets the following corner cases:
- **Saturated amounts (-64 and +63).** A design that took the amount modulo the width would return a lightly shifted value instead of a saturated one.
- **Right shifts of negative operands.** If the arithmetic and logical fills were swapped, the top bits would show it at once.
- **Rotates across bit 39 and bit 0.** These catch a rotate that behaves as a plain shift and drops bits.
- **Sign counts of 0, all-ones, and values one bit from either extreme.** A count that is off by one, or that includes the sign bit, would be visible.
- **Fields that run past bit 39 or start past it.** These expose missing length saturation, which would leak garbage or drop the sign in signed extracts.
- **Zero-length fields.** These also test length saturation.
- **Idle cycles and narrow-mode operands whose bit 31 is set.** Idle cycles catch outputs that drift while idle. The narrow-mode cases catch a zero-extension mistake.

// File: rtl/wshf_pkg.sv
package wshf_pkg;

    localparam int DATA_W   = 40;
    localparam int NARROW_W = 32;
    localparam int CNT_W    = $clog2(DATA_W);
    localparam int LEN_W    = CNT_W + 1;

    typedef enum logic [2:0] {
        SH_ARITH    = 3'd0,
        SH_LOGIC    = 3'd1,
        SH_ROTATE   = 3'd2,
        SH_SIGNCNT  = 3'd3,
        SH_XTRACT_U = 3'd4,
        SH_XTRACT_S = 3'd5,
        SH_INSERT   = 3'd6,
        SH_PASS     = 3'd7
    } shf_op_e;

    // decoded controls shared by the shifter and the field unit
    typedef struct packed {
        logic             left;
        logic [CNT_W-1:0] mag;
        logic [CNT_W-1:0] pos;
        logic [LEN_W-1:0] len;
    } shf_ctl_t;

    typedef struct packed {
        logic              valid;
        logic              zero;
        logic              neg;
        logic [DATA_W-1:0] data;
    } shf_res_t;

    function automatic logic [LEN_W-1:0] sat_to(input logic [LEN_W-1:0] v,
                                                 input logic [LEN_W-1:0] lim);
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/wshf_decode.sv
module wshf_decode
    import wshf_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int CW = CNT_W,
    parameter int LW = LEN_W
) (
    input  logic [CW:0]   shamt,
    input  logic [CW-1:0] fpos,
    input  logic [CW-1:0] flen,
    output shf_ctl_t      ctl
);

    logic [LW-1:0] neg_amt;
    logic [LW-1:0] abs_amt;
    logic [LW-1:0] mag_sat;
    logic [LW-1:0] pos_sat;
    logic [LW-1:0] room;
    logic [LW-1:0] len_sat;

    always_comb begin
        neg_amt = ~shamt + 1'b1;
        abs_amt = shamt[CW] ? neg_amt : shamt;
        mag_sat = sat_to(abs_amt, LW'(W - 1));
        pos_sat = sat_to({1'b0, fpos}, LW'(W - 1));
        room    = LW'(W) - pos_sat;
        len_sat = sat_to({1'b0, flen}, room);

        ctl.left = ~shamt[CW];
        ctl.mag  = mag_sat[CW-1:0];
        ctl.pos  = pos_sat[CW-1:0];
        ctl.len  = len_sat;
    end

endmodule

// File: rtl/wshf_barrel.sv
module wshf_barrel
    import wshf_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic [W-1:0]  x,
    input  logic [CW-1:0] amt,
    input  logic          left,
    input  logic          arith,
    input  logic          rotate,
    output logic [W-1:0]  y
);

    // one right-going log shifter; left moves use bit reversal around it
    logic [W-1:0] x_rev;
    logic [W-1:0] y_rev;
    logic [W-1:0] stg [CW+1];
    logic         fill;

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign x_rev[i] = x[W-1-i];
        assign y_rev[i] = stg[CW][W-1-i];
    end

    assign fill   = arith & ~left & x[W-1];
    assign stg[0] = left ? x_rev : x;

    for (genvar i = 0; i < CW; i++) begin : g_stage
        localparam int S = 1 << i;
        if (S < W) begin : g_live
            assign stg[i+1] = !amt[i] ? stg[i] :
                              rotate  ? {stg[i][S-1:0], stg[i][W-1:S]} :
                                        {{S{fill}}, stg[i][W-1:S]};
        end else begin : g_skip
            assign stg[i+1] = stg[i];
        end
    end

    assign y = left ? y_rev : stg[CW];

endmodule

// File: rtl/wshf_signcnt.sv
module wshf_signcnt
    import wshf_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic [W-1:0]  x,
    output logic [CW-1:0] cnt
);

    logic run;

    always_comb begin
        cnt = '0;
        run = 1'b1;
        for (int i = W - 2; i >= 0; i--) begin
            if (run && (x[i] == x[W-1])) begin
                cnt = cnt + CW'(1);
            end else begin
                run = 1'b0;
            end
        end
    end

endmodule

// File: rtl/wshf_field.sv
module wshf_field
    import wshf_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int CW = CNT_W,
    parameter int LW = LEN_W
) (
    input  logic [W-1:0]  x,
    input  logic [W-1:0]  dsrc,
    input  logic [CW-1:0] pos,
    input  logic [LW-1:0] len,
    input  logic          sgn,
    output logic [W-1:0]  ext_y,
    output logic [W-1:0]  dep_y
);

    logic [W-1:0]  mask_lo;
    logic [W-1:0]  mask_at;
    logic [W-1:0]  aligned;
    logic [LW-1:0] top_idx;
    logic          top_bit;

    for (genvar i = 0; i < W; i++) begin : g_mask
        assign mask_lo[i] = (len > LW'(i));
    end

    always_comb begin
        aligned = x >> pos;
        top_idx = (len == '0) ? '0 : (len - LW'(1));
        top_bit = (len != '0) & sgn & aligned[top_idx[CW-1:0]];
        ext_y   = (aligned & mask_lo) | (top_bit ? ~mask_lo : '0);

        mask_at = mask_lo << pos;
        dep_y   = (x & ~mask_at) | ((dsrc << pos) & mask_at);
    end

endmodule

// File: rtl/wide_shifter.sv
module wide_shifter
    import wshf_pkg::*;
#(
    parameter int NW = NARROW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] src_a,
    input  logic              narrow,
    input  logic [CNT_W:0]    shamt,
    input  logic [CNT_W-1:0]  fpos,
    input  logic [CNT_W-1:0]  flen,
    input  logic [DATA_W-1:0] dep_src,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              zero_flag,
    output logic              sign_flag
);

    localparam int W  = DATA_W;
    localparam int CW = CNT_W;

    shf_op_e      opc;
    shf_ctl_t     ctl;
    logic [W-1:0] opnd;
    logic [W-1:0] shifted;
    logic [CW-1:0] sgn_cnt;
    logic [W-1:0] ext_val;
    logic [W-1:0] dep_val;
    logic [W-1:0] nxt_data;
    shf_res_t     res_q;

    assign opc  = shf_op_e'(op);
    assign opnd = narrow ? {{(W-NW){src_a[NW-1]}}, src_a[NW-1:0]} : src_a;

    wshf_decode #(.W(W), .CW(CW), .LW(LEN_W)) u_decode (
        .shamt (shamt),
        .fpos  (fpos),
        .flen  (flen),
        .ctl   (ctl)
    );

    wshf_barrel #(.W(W), .CW(CW)) u_barrel (
        .x      (opnd),
        .amt    (ctl.mag),
        .left   (ctl.left),
        .arith  (opc == SH_ARITH),
        .rotate (opc == SH_ROTATE),
        .y      (shifted)
    );

    wshf_signcnt #(.W(W), .CW(CW)) u_signcnt (
        .x   (opnd),
        .cnt (sgn_cnt)
    );

    wshf_field #(.W(W), .CW(CW), .LW(LEN_W)) u_field (
        .x     (opnd),
        .dsrc  (dep_src),
        .pos   (ctl.pos),
        .len   (ctl.len),
        .sgn   (opc == SH_XTRACT_S),
        .ext_y (ext_val),
        .dep_y (dep_val)
    );

    always_comb begin
        unique case (opc)
            SH_ARITH, SH_LOGIC, SH_ROTATE: nxt_data = shifted;
            SH_SIGNCNT:                    nxt_data = {{(W-CW){1'b0}}, sgn_cnt};
            SH_XTRACT_U, SH_XTRACT_S:      nxt_data = ext_val;
            SH_INSERT:                     nxt_data = dep_val;
            default:                       nxt_data = opnd;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= in_valid;
            if (in_valid) begin
                res_q.data <= nxt_data;
                res_q.zero <= (nxt_data == '0);
                res_q.neg  <= nxt_data[W-1];
            end
        end
    end

    assign out_valid = res_q.valid;
    assign result    = res_q.data;
    assign zero_flag = res_q.zero;
    assign sign_flag = res_q.neg;

endmodule

// File: rtl/wshf_checker.sv
module wshf_checker
    import wshf_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int CW = CNT_W
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [2:0]   op,
    input logic [W-1:0] src_a,
    input logic         narrow,
    input logic [CW:0]  shamt,
    input logic [CW-1:0] flen,
    input logic         out_valid,
    input logic [W-1:0] result
);

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    a_r1_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> $stable(result));

    a_r7_count_range: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past(op) == 3'(SH_SIGNCNT))
        |-> ((result[W-1:CW] == '0) && (result[CW-1:0] <= CW'(W - 1))));

    a_r6_rotate_keeps_ones: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past(op) == 3'(SH_ROTATE) && !$past(narrow))
        |-> ($countones(result) == $countones($past(src_a))));

    a_r5_logical_right_top_clear: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past(op) == 3'(SH_LOGIC) && $past(shamt[CW]))
        |-> !result[W-1]);

    a_r9_empty_field_zero: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past(flen) == '0 &&
         ($past(op) == 3'(SH_XTRACT_U) || $past(op) == 3'(SH_XTRACT_S)))
        |-> (result == '0));

endmodule

bind wide_shifter wshf_checker #(.W(wshf_pkg::DATA_W), .CW(wshf_pkg::CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .src_a     (src_a),
    .narrow    (narrow),
    .shamt     (shamt),
    .flen      (flen),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/wide_shifter_bench.sv
module wide_shifter_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [39:0] src_a = '0;
    logic        narrow = 1'b0;
    logic [6:0]  shamt = '0;
    logic [5:0]  fpos = '0;
    logic [5:0]  flen = '0;
    logic [39:0] dep_src = '0;
    logic        out_valid;
    logic [39:0] result;
    logic        zero_flag;
    logic        sign_flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [39:0] last_exp = '0;

    always #10 clk = ~clk;

    wide_shifter u_wide_shifter (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .src_a(src_a),
        .narrow(narrow), .shamt(shamt), .fpos(fpos), .flen(flen),
        .dep_src(dep_src), .out_valid(out_valid), .result(result),
        .zero_flag(zero_flag), .sign_flag(sign_flag)
    );

    function automatic logic [39:0] model(input logic [2:0] o, input logic [39:0] a,
                                          input logic nar, input logic [6:0] sh,
                                          input logic [5:0] p, input logic [5:0] l,
                                          input logic [39:0] d);
        logic [39:0] x, r;
        int s, m, pe, le, c;
        logic run;
        x  = nar ? {{8{a[31]}}, a[31:0]} : a;
        s  = int'($signed(sh));
        m  = (s < 0) ? -s : s;
        if (m > 39) m = 39;
        pe = int'(p);
        if (pe > 39) pe = 39;
        le = int'(l);
        if (le > 40 - pe) le = 40 - pe;
        r = '0;
        case (o)
            3'd0, 3'd1: for (int i = 0; i < 40; i++) begin
                if (s >= 0) r[i] = (i >= m) ? x[i-m] : 1'b0;
                else        r[i] = (i + m <= 39) ? x[i+m] : ((o == 3'd0) ? x[39] : 1'b0);
            end
            3'd2: for (int i = 0; i < 40; i++) begin
                if (s >= 0) r[(i+m)%40] = x[i];
                else        r[i] = x[(i+m)%40];
            end
            3'd3: begin
                c = 0; run = 1'b1;
                for (int i = 38; i >= 0; i--) begin
                    if (run && x[i] == x[39]) c++;
                    else run = 1'b0;
                end
                r = 40'(c);
            end
            3'd4, 3'd5: begin
                for (int i = 0; i < le; i++) r[i] = x[pe+i];
                if (o == 3'd5 && le > 0)
                    for (int i = le; i < 40; i++) r[i] = x[pe+le-1];
            end
            3'd6: begin
                r = x;
                for (int i = 0; i < le; i++) r[pe+i] = d[i];
            end
            default: r = x;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [2:0] o);
        case (o)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R8";
            3'd5: return "R9";
            3'd6: return "R10";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [2:0] o, input logic [39:0] a,
                          input logic nar, input logic [6:0] sh, input logic [5:0] p,
                          input logic [5:0] l, input logic [39:0] d);
        logic [39:0] e;
        e = model(o, a, nar, sh, p, l, d);
        in_valid = 1'b1; op = o; src_a = a; narrow = nar; shamt = sh;
        fpos = p; flen = l; dep_src = d;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, result, e);
        check({tag, " R1 valid"}, 40'(out_valid), 40'd1);
        check({tag, " R11 zero"}, 40'(zero_flag), 40'(e == '0));
        check({tag, " R11 sign"}, 40'(sign_flag), 40'(e[39]));
        last_exp = e;
    endtask

    task automatic idle_cycle();
        in_valid = 1'b0;
        op = 3'($urandom); src_a = {$urandom, $urandom}; shamt = 7'($urandom);
        @(negedge clk);
        check("R1 idle valid", 40'(out_valid), 40'd0);
        check("R1 idle hold", result, last_exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [39:0] rv;
        logic [2:0]  ro;
        void'($urandom(32'h5EED_0A17));
        repeat (3) @(negedge clk);
        check("R1 reset valid", 40'(out_valid), 40'd0);
        check("R1 reset result", result, '0);
        check("R1 reset flags", 40'({zero_flag, sign_flag}), 40'd0);
        rst = 1'b0;

        // directed corners
        run_op("R4 left", 3'd0, 40'h00_0000_0001, 1'b0, 7'd4, 6'd0, 6'd0, '0);
        run_op("R4 right neg", 3'd0, 40'h80_0000_0000, 1'b0, -7'sd4, 6'd0, 6'd0, '0);
        run_op("R5 right neg", 3'd1, 40'h80_0000_0000, 1'b0, -7'sd4, 6'd0, 6'd0, '0);
        run_op("R3 sat -64", 3'd0, 40'h80_0000_0000, 1'b0, 7'h40, 6'd0, 6'd0, '0);
        run_op("R3 sat +63", 3'd1, 40'h00_0000_0001, 1'b0, 7'd63, 6'd0, 6'd0, '0);
        run_op("R3 zero amt", 3'd0, 40'hA5_1234_5678, 1'b0, 7'd0, 6'd0, 6'd0, '0);
        run_op("R6 rot left wrap", 3'd2, 40'h80_0000_0001, 1'b0, 7'd1, 6'd0, 6'd0, '0);
        run_op("R6 rot right wrap", 3'd2, 40'h00_0000_0001, 1'b0, -7'sd1, 6'd0, 6'd0, '0);
        run_op("R6 rot max", 3'd2, 40'hC0_0000_0003, 1'b0, 7'h40, 6'd0, 6'd0, '0);
        run_op("R7 zero", 3'd3, 40'h00_0000_0000, 1'b0, 7'd0, 6'd0, 6'd0, '0);
        run_op("R7 ones", 3'd3, 40'hFF_FFFF_FFFF, 1'b0, 7'd0, 6'd0, 6'd0, '0);
        run_op("R7 none", 3'd3, 40'h40_0000_0000, 1'b0, 7'd0, 6'd0, 6'd0, '0);
        run_op("R7 one lsb", 3'd3, 40'h00_0000_0001, 1'b0, 7'd0, 6'd0, 6'd0, '0);
        run_op("R7 neg lsb", 3'd3, 40'hFF_FFFF_FFFE, 1'b0, 7'd0, 6'd0, 6'd0, '0);
        run_op("R2 narrow ext", 3'd7, 40'h12_8000_0000, 1'b1, 7'd0, 6'd0, 6'd0, '0);
        run_op("R2 wide keep", 3'd7, 40'h12_8000_0000, 1'b0, 7'd0, 6'd0, 6'd0, '0);
        run_op("R2 narrow shift", 3'd0, 40'h00_8000_0000, 1'b1, -7'sd8, 6'd0, 6'd0, '0);
        run_op("R8 mid", 3'd4, 40'h00_0000_0AB0, 1'b0, 7'd0, 6'd4, 6'd8, '0);
        run_op("R9 mid", 3'd5, 40'h00_0000_0AB0, 1'b0, 7'd0, 6'd4, 6'd8, '0);
        run_op("R8 overhang", 3'd4, 40'hF0_0000_0000, 1'b0, 7'd0, 6'd36, 6'd20, '0);
        run_op("R9 overhang", 3'd5, 40'hF0_0000_0000, 1'b0, 7'd0, 6'd36, 6'd20, '0);
        run_op("R8 pos sat", 3'd4, 40'h80_0000_0000, 1'b0, 7'd0, 6'd50, 6'd1, '0);
        run_op("R9 len zero", 3'd5, 40'hFF_FFFF_FFFF, 1'b0, 7'd0, 6'd7, 6'd0, '0);
        run_op("R10 mid", 3'd6, 40'hFF_FFFF_FFFF, 1'b0, 7'd0, 6'd8, 6'd8, 40'h0);
        run_op("R10 overhang", 3'd6, 40'h00_0000_0000, 1'b0, 7'd0, 6'd36, 6'd10, 40'h3F);
        run_op("R10 narrow dst", 3'd6, 40'h00_8000_0000, 1'b1, 7'd0, 6'd0, 6'd4, 40'h5);
        run_op("R11 zero out", 3'd1, 40'h00_0000_0002, 1'b0, 7'd39, 6'd0, 6'd0, '0);
        run_op("R12 pass", 3'd7, 40'h7F_0F0F_0F0F, 1'b0, 7'd5, 6'd3, 6'd3, '1);
        idle_cycle();

        // constrained random
        for (int k = 0; k < 3000; k++) begin
            rv = {$urandom, $urandom};
            ro = 3'($urandom);
            if (ro == 3'd3 && $urandom_range(0, 1) == 1) rv = 40'($signed(rv) >>> $urandom_range(0, 39));
            run_op(tag_of(ro), ro, rv, 1'($urandom_range(0, 3) == 0),
                   ($urandom_range(0, 7) == 0) ? 7'($urandom) : 7'($signed($urandom_range(0, 84)) - 42),
                   6'($urandom_range(0, 45)), 6'($urandom_range(0, 45)), {$urandom, $urandom});
            if (k % 10 == 9) idle_cycle();
        end

        finish_run();
    end

endmodule